// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register file behind a bank of general-purpose pins. It holds up to 56 pins, grouped into seven banks of eight. Each pin has a function-select bit, a direction bit, an output value bit, a pull-down enable bit and a sampled input bit. A host reaches these registers over a simple synchronous byte bus. The bus has an 8-bit address, 8-bit data, and a per-bit write mask, so that a write changes only the bits the host selects.

Pins are numbered from 1. Pin n sits in bank (n-1)/8 at bit (n-1) mod 8, and pin-side vectors carry pin n at index n-1. A small range of pins, 51 to 54 by default, also has a packed 2-bit pull field, which can request a pull-up as well as a pull-down. For those pins the field takes the place of the plain pull-down bit. The block also holds an alternate-function byte and a narrow voltage-select field. It drives these straight to the pins, along with output enables, output values, pull requests, and each pin's logical level.

Top module: `gpio_bank_regfile`

## Requirements
- R1: While reset is high and after it ends, every direction, output, select and pull-down bit is 0 and every pin-side output is 0. Each 2-bit pull field holds 01, so offset 0x48 reads 0x55.
- R2: A write changes only the register bits whose host_wmask bit is 1. Every other bit keeps its value.
- R3: The register groups sit at these bases, with the low address nibble giving the bank: select at 0x00, direction at 0x10, output at 0x20, pull-down at 0x30, input at 0x40. Bank nibbles of 7 or more in these groups read 0x00, and writes to them are dropped. Every address with an upper nibble above 5 reads 0x00.
- R4: Pin n corresponds to bit (n-1) mod 8 of bank (n-1)/8, and to index n-1 of every pin-side vector.
- R5: The input registers at 0x40-0x46 read the pads through a two-flop synchronizer. Host writes to them have no effect. A pad change that is present before a read request is not yet seen by that read.
- R6: A direction bit of 1 makes the pin an output: pin_oe is 1 and pin_out carries the output register bit. Both pin-side outputs lag the register by one clock.
- R7: pin_level gives the output register bit when the pin's direction is 1, and the synchronized input bit when it is 0.
- R8: Offset 0x48 holds a 2-bit pull field for each pin from PULL_FIRST_PIN to PULL_FIRST_PIN+3. The field for pin p is at bits 2*(p-PULL_FIRST_PIN). The encoding is 00 pull down, 01 none, 10 none, 11 pull up. For these pins the field alone sets pin_pd_en and pin_pu_en, and the pull-down bit is ignored.
- R9: For pins outside the pull-field range, pin_pd_en follows the pull-down register bit and pin_pu_en is always 0.
- R10: When a write changes a direction bit from 0 to 1, it also clears that pin's pull-down bit. If the pin is in the pull-field range, its field is set to 01.
- R11: Offset 0x47 holds a 2-bit voltage select, whose bits 7:2 read 0. Offset 0x50 holds the 8-bit alternate-function byte. Both are driven on the vsel and alt_func ports.
- R12: host_rdata updates on the clock edge where host_re is sampled high, and keeps its value while host_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Write strobe |
| host_re | input | 1 | Read strobe |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write data |
| host_wmask | input | 8 | Per-bit write enable |
| host_rdata | output | 8 | Registered read data |
| pad_in | input | 56 | Raw pad levels, index n-1 is pin n |
| pin_oe | output | 56 | Output enable per pin |
| pin_out | output | 56 | Output value per pin |
| pin_pd_en | output | 56 | Pull-down request per pin |
| pin_pu_en | output | 56 | Pull-up request per pin |
| pin_func_sel | output | 56 | Function-select bit per pin |
| pin_level | output | 56 | Logical level per pin |
| alt_func | output | 8 | Alternate-function byte |
| vsel | output | 2 | Voltage-select field |

## Verification
A table of masked writes, each followed by a read-back, touches every register group. The masks are partial and the banks are the first, the last and the nonexistent, so the table separates masking faults from address-decode faults. Pull behaviour is driven with a field value that uses all four encodings at once, before and after the pull-down bank is filled with ones. This separates the field override from the plain pull-down path, and a direction write then shows the clearing side effect on both. Pad changes are read back at once and again later, which exposes a missing synchronizer stage. Pins that are outputs and pins that are inputs are both given a high pad, to show which source pin_level uses.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

  // Upper address nibble selects a register group.
  typedef enum logic [3:0] {
    GRP_FSEL = 4'h0,
    GRP_DIR  = 4'h1,
    GRP_OUT  = 4'h2,
    GRP_PDN  = 4'h3,
    GRP_IN   = 4'h4,
    GRP_ALT  = 4'h5
  } reg_group_e;

  // Extra registers that live in the input group's address space.
  localparam logic [3:0] MISC_VSEL_IDX = 4'h7;
  localparam logic [3:0] MISC_PULL_IDX = 4'h8;

  // 2-bit pull field encoding.
  localparam logic [1:0] PULL_DOWN     = 2'd0;
  localparam logic [1:0] PULL_NONE     = 2'd1;
  localparam logic [1:0] PULL_NONE_ALT = 2'd2;
  localparam logic [1:0] PULL_UP       = 2'd3;

  typedef struct packed {
    logic fsel;
    logic dir;
    logic outv;
    logic pdn;
    logic vsel;
    logic pull;
    logic alt;
  } wr_hit_t;

endpackage

// File: rtl/gpio_rf_sync.sv
module gpio_rf_sync #(
  parameter int WIDTH  = 56,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_rf_bankgrp.sv
// One register group: NUM_BANKS bytes, masked writes, per-bit clear.
module gpio_rf_bankgrp #(
  parameter int NUM_BANKS = 7,
  parameter int BANK_W    = 8,
  parameter int IDX_W     = 4,
  localparam int TOTAL    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] wmask,
  input  logic [TOTAL-1:0]  clr_vec,
  output logic [TOTAL-1:0]  q
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] bank_nxt;
    logic              hit;

    assign hit = wr_en && (wr_idx == IDX_W'(b));

    always_comb begin
      bank_nxt = bank_q;
      if (hit) begin
        bank_nxt = (bank_q & ~wmask) | (wdata & wmask);
      end
      bank_nxt = bank_nxt & ~clr_vec[b*BANK_W +: BANK_W];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q <= '0;
      end else begin
        bank_q <= bank_nxt;
      end
    end

    assign q[b*BANK_W +: BANK_W] = bank_q;
  end

endmodule

// File: rtl/gpio_rf_pullfield.sv
// Packed 2-bit pull fields with masked writes and forced "none".
module gpio_rf_pullfield
  import gpio_rf_pkg::*;
#(
  parameter int FIELDS = 4,
  localparam int FW    = 2 * FIELDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FW-1:0]     wdata,
  input  logic [FW-1:0]     wmask,
  input  logic [FIELDS-1:0] force_none,
  output logic [FW-1:0]     q
);

  logic [FW-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      nxt = (q & ~wmask) | (wdata & wmask);
    end
    for (int f = 0; f < FIELDS; f++) begin
      if (force_none[f]) begin
        nxt[2*f +: 2] = PULL_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= {FIELDS{PULL_NONE}};
    end else begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/gpio_rf_pinmap.sv
// Registered pin-side outputs.
module gpio_rf_pinmap #(
  parameter int NPINS = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] outv,
  input  logic [NPINS-1:0] fsel,
  input  logic [NPINS-1:0] in_sync,
  input  logic [NPINS-1:0] pd_req,
  input  logic [NPINS-1:0] pu_req,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_pd_en,
  output logic [NPINS-1:0] pin_pu_en,
  output logic [NPINS-1:0] pin_func_sel,
  output logic [NPINS-1:0] pin_level
);

  logic [NPINS-1:0] level_c;

  for (genvar p = 0; p < NPINS; p++) begin : g_level
    assign level_c[p] = dir[p] ? outv[p] : in_sync[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe       <= '0;
      pin_out      <= '0;
      pin_pd_en    <= '0;
      pin_pu_en    <= '0;
      pin_func_sel <= '0;
      pin_level    <= '0;
    end else begin
      pin_oe       <= dir;
      pin_out      <= outv;
      pin_pd_en    <= pd_req;
      pin_pu_en    <= pu_req;
      pin_func_sel <= fsel;
      pin_level    <= level_c;
    end
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_rf_pkg::*;
#(
  parameter int NUM_BANKS       = 7,
  parameter int BANK_W          = 8,
  parameter int ADDR_W          = 8,
  parameter int PULL_FIRST_PIN  = 51,
  parameter int PULL_PIN_COUNT  = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int VSEL_W          = 2,
  localparam int NPINS          = NUM_BANKS * BANK_W,
  localparam int DATA_W         = BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] host_wmask,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_pd_en,
  output logic [NPINS-1:0]  pin_pu_en,
  output logic [NPINS-1:0]  pin_func_sel,
  output logic [NPINS-1:0]  pin_level,
  output logic [DATA_W-1:0] alt_func,
  output logic [VSEL_W-1:0] vsel
);

  localparam int IDX_W   = 4;
  localparam int GRP_W   = ADDR_W - IDX_W;
  localparam int PULL_W  = 2 * PULL_PIN_COUNT;
  localparam int PULL_LO = PULL_FIRST_PIN - 1;  // vector index of first field pin

  // ---------------- address decode ----------------
  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  wr_hit_t          wr;

  assign grp = host_addr[ADDR_W-1:IDX_W];
  assign idx = host_addr[IDX_W-1:0];

  always_comb begin
    wr      = '0;
    wr.fsel = host_we && (grp == GRP_W'(GRP_FSEL));
    wr.dir  = host_we && (grp == GRP_W'(GRP_DIR));
    wr.outv = host_we && (grp == GRP_W'(GRP_OUT));
    wr.pdn  = host_we && (grp == GRP_W'(GRP_PDN));
    wr.vsel = host_we && (grp == GRP_W'(GRP_IN)) && (idx == MISC_VSEL_IDX);
    wr.pull = host_we && (grp == GRP_W'(GRP_IN)) && (idx == MISC_PULL_IDX);
    wr.alt  = host_we && (grp == GRP_W'(GRP_ALT)) && (idx == '0);
  end

  // ---------------- register groups ----------------
  logic [NPINS-1:0]  fsel_flat, dir_flat, out_flat, pdn_flat, in_flat;
  logic [NPINS-1:0]  dir_rise;
  logic [PULL_W-1:0] pull_q;
  logic [PULL_PIN_COUNT-1:0] pull_force;

  // Bits that a direction write moves from input to output.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rise
    assign dir_rise[b*BANK_W +: BANK_W] =
      (wr.dir && (idx == IDX_W'(b))) ?
      (host_wdata & host_wmask & ~dir_flat[b*BANK_W +: BANK_W]) : '0;
  end

  for (genvar f = 0; f < PULL_PIN_COUNT; f++) begin : g_force
    assign pull_force[f] = dir_rise[PULL_LO + f];
  end

  gpio_rf_bankgrp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_fsel (
    .clk(clk), .rst(rst), .wr_en(wr.fsel), .wr_idx(idx), .wdata(host_wdata),
    .wmask(host_wmask), .clr_vec('0), .q(fsel_flat));

  gpio_rf_bankgrp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_dir (
    .clk(clk), .rst(rst), .wr_en(wr.dir), .wr_idx(idx), .wdata(host_wdata),
    .wmask(host_wmask), .clr_vec('0), .q(dir_flat));

  gpio_rf_bankgrp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst), .wr_en(wr.outv), .wr_idx(idx), .wdata(host_wdata),
    .wmask(host_wmask), .clr_vec('0), .q(out_flat));

  gpio_rf_bankgrp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_pdn (
    .clk(clk), .rst(rst), .wr_en(wr.pdn), .wr_idx(idx), .wdata(host_wdata),
    .wmask(host_wmask), .clr_vec(dir_rise), .q(pdn_flat));

  gpio_rf_pullfield #(.FIELDS(PULL_PIN_COUNT)) u_pull (
    .clk(clk), .rst(rst), .wr_en(wr.pull), .wdata(host_wdata[PULL_W-1:0]),
    .wmask(host_wmask[PULL_W-1:0]), .force_none(pull_force), .q(pull_q));

  gpio_rf_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_flat));

  // Narrow misc registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      vsel     <= '0;
      alt_func <= '0;
    end else begin
      if (wr.vsel) begin
        vsel <= (vsel & ~host_wmask[VSEL_W-1:0]) |
                (host_wdata[VSEL_W-1:0] & host_wmask[VSEL_W-1:0]);
      end
      if (wr.alt) begin
        alt_func <= (alt_func & ~host_wmask) | (host_wdata & host_wmask);
      end
    end
  end

  // ---------------- pull resolution ----------------
  logic [NPINS-1:0] pd_req, pu_req;

  for (genvar p = 0; p < NPINS; p++) begin : g_pull
    if (p >= PULL_LO && p < PULL_LO + PULL_PIN_COUNT) begin : g_field
      localparam int F = p - PULL_LO;
      assign pd_req[p] = (pull_q[2*F +: 2] == PULL_DOWN);
      assign pu_req[p] = (pull_q[2*F +: 2] == PULL_UP);
    end else begin : g_plain
      assign pd_req[p] = pdn_flat[p];
      assign pu_req[p] = 1'b0;
    end
  end

  gpio_rf_pinmap #(.NPINS(NPINS)) u_pins (
    .clk(clk), .rst(rst), .dir(dir_flat), .outv(out_flat), .fsel(fsel_flat),
    .in_sync(in_flat), .pd_req(pd_req), .pu_req(pu_req),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pd_en(pin_pd_en),
    .pin_pu_en(pin_pu_en), .pin_func_sel(pin_func_sel), .pin_level(pin_level));

  // ---------------- read path ----------------
  function automatic logic [DATA_W-1:0] pick_bank(input logic [NPINS-1:0] vec,
                                                  input logic [IDX_W-1:0] sel);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel == IDX_W'(b)) r = vec[b*BANK_W +: BANK_W];
    end
    return r;
  endfunction

  logic [DATA_W-1:0] rd_c;

  always_comb begin
    rd_c = '0;
    if (grp == GRP_W'(GRP_FSEL))      rd_c = pick_bank(fsel_flat, idx);
    else if (grp == GRP_W'(GRP_DIR))  rd_c = pick_bank(dir_flat, idx);
    else if (grp == GRP_W'(GRP_OUT))  rd_c = pick_bank(out_flat, idx);
    else if (grp == GRP_W'(GRP_PDN))  rd_c = pick_bank(pdn_flat, idx);
    else if (grp == GRP_W'(GRP_IN)) begin
      if (idx == MISC_VSEL_IDX)       rd_c = DATA_W'(vsel);
      else if (idx == MISC_PULL_IDX)  rd_c = DATA_W'(pull_q);
      else                            rd_c = pick_bank(in_flat, idx);
    end else if (grp == GRP_W'(GRP_ALT) && idx == '0) begin
      rd_c = alt_func;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      host_rdata <= rd_c;
    end
  end

endmodule

// File: rtl/gpio_rf_checker.sv
module gpio_rf_checker #(
  parameter int NPINS  = 56,
  parameter int DATA_W = 8,
  parameter int GRP_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              host_re,
  input logic [GRP_W-1:0]  host_grp,
  input logic [DATA_W-1:0] host_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pin_pd_en,
  input logic [NPINS-1:0]  pin_pu_en,
  input logic [NPINS-1:0]  dir_flat,
  input logic [NPINS-1:0]  pdn_flat
);

  AST_RESET_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && pin_pd_en == '0 && pin_pu_en == '0)); // R1

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pin_oe == $past(dir_flat))); // R6

  AST_NO_PULL_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    (pin_pd_en & pin_pu_en) == '0); // R8

  AST_SWITCH_DROPS_PULLDOWN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((dir_flat & ~$past(dir_flat) & pdn_flat) == '0)); // R10

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_re && host_grp > GRP_W'(5)) |=> (host_rdata == '0)); // R3

endmodule

bind gpio_bank_regfile gpio_rf_checker #(
  .NPINS(NPINS), .DATA_W(DATA_W), .GRP_W(ADDR_W - 4)
) i_chk (
  .clk(clk), .rst(rst), .host_re(host_re), .host_grp(host_addr[ADDR_W-1:4]),
  .host_rdata(host_rdata), .pin_oe(pin_oe), .pin_pd_en(pin_pd_en),
  .pin_pu_en(pin_pu_en), .dir_flat(dir_flat), .pdn_flat(pdn_flat)
);

// File: tb/test_gpio_bank_regfile.sv
module test_gpio_bank_regfile;

  logic        clk = 0;
  logic        rst = 1;
  logic        host_we = 0, host_re = 0;
  logic [7:0]  host_addr = '0, host_wdata = '0, host_wmask = '0;
  logic [7:0]  host_rdata;
  logic [55:0] pad_in = '0;
  logic [55:0] pin_oe, pin_out, pin_pd_en, pin_pu_en, pin_func_sel, pin_level;
  logic [7:0]  alt_func;
  logic [1:0]  vsel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  gpio_bank_regfile i_gpio_bank_regfile (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_wmask(host_wmask),
    .host_rdata(host_rdata), .pad_in(pad_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pd_en(pin_pd_en), .pin_pu_en(pin_pu_en), .pin_func_sel(pin_func_sel),
    .pin_level(pin_level), .alt_func(alt_func), .vsel(vsel));

  // {addr, wdata, wmask, expected read-back}
  localparam logic [31:0] VEC [12] = '{
    32'h00_A5_FF_A5,  // R2 R3 full write of select bank 0
    32'h00_5A_0F_AA,  // R2 low nibble only
    32'h16_FF_81_81,  // R2 R4 direction bank 6, pins 49 and 56
    32'h17_FF_FF_00,  // R3 bank 7 absent
    32'h26_3C_FF_3C,  // R3 output bank 6
    32'h33_C3_FF_C3,  // R3 pull-down bank 3
    32'h47_FF_FF_03,  // R11 voltage select is 2 bits
    32'h50_96_FF_96,  // R11 alternate-function byte
    32'h48_E4_FF_E4,  // R8 all four encodings
    32'h45_FF_FF_00,  // R5 input bank is read-only
    32'h60_FF_FF_00,  // R3 unmapped group
    32'h08_FF_FF_00   // R3 select bank index 8 absent
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic [7:0] m);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d; host_wmask = m;
    @(negedge clk);
    host_we = 0; host_wmask = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_re = 1; host_addr = a;
    @(negedge clk);
    host_re = 0;
    d = host_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 pin_oe after reset", 64'(pin_oe), 64'h0);
    check("R1 pin_pd_en after reset", 64'(pin_pd_en), 64'h0);
    check("R1 pin_pu_en after reset", 64'(pin_pu_en), 64'h0);
    do_read(8'h48, rd); check("R1 pull fields read none", 64'(rd), 64'h55);
    do_read(8'h10, rd); check("R1 direction bank 0", 64'(rd), 64'h00);

    // Table walk: R2 R3 R5 R8 R11
    for (int i = 0; i < 12; i++) begin
      do_write(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
      do_read(VEC[i][31:24], rd);
      check($sformatf("R2/R3 table entry %0d addr %h", i, VEC[i][31:24]),
            64'(rd), 64'(VEC[i][7:0]));
    end
    settle();

    // R6 R4 pin-side mapping
    check("R6 pin_oe bank 6", 64'(pin_oe), 64'(56'h81) << 48);
    check("R6 pin_out bank 6", 64'(pin_out), 64'(56'h3C) << 48);
    check("R4 pin_func_sel bank 0", 64'(pin_func_sel), 64'hAA);
    check("R11 alt_func port", 64'(alt_func), 64'h96);
    check("R11 vsel port", 64'(vsel), 64'h3);
    check("R9 pin_pd_en bank 3", 64'(pin_pd_en[31:24]), 64'hC3);
    check("R8 field pull-down on pin 51", 64'(pin_pd_en[55:48]), 64'h04);
    check("R8 field pull-up on pin 54", 64'(pin_pu_en), 64'(1) << 53);

    // R8 pull-down bits ignored inside the field range
    do_write(8'h36, 8'hFF, 8'hFF);
    settle();
    check("R8 pd bank 6 with plain bits set", 64'(pin_pd_en[55:48]), 64'hC7);

    // R10 switching pin 51 to output
    do_write(8'h16, 8'h04, 8'h04);
    do_read(8'h36, rd); check("R10 pull-down bit cleared", 64'(rd), 64'hFB);
    do_read(8'h48, rd); check("R10 field forced to none", 64'(rd), 64'hE5);
    check("R10 pin 51 pull released", 64'(pin_pd_en[55:48]), 64'hC3);

    // R9 pull-up never outside range
    do_write(8'h30, 8'hFF, 8'hFF);
    settle();
    check("R9 pd bank 0 follows register", 64'(pin_pd_en[7:0]), 64'hFF);
    check("R9 pu only on pin 54", 64'(pin_pu_en), 64'(1) << 53);

    // R5 synchronizer and R7 logical level
    @(negedge clk);
    pad_in = 56'h1 | (56'h1 << 48);
    do_read(8'h40, rd); check("R5 pad not yet visible", 64'(rd), 64'h00);
    repeat (3) @(negedge clk);
    do_read(8'h40, rd); check("R5 pad visible after sync", 64'(rd), 64'h01);
    do_read(8'h46, rd); check("R5 input samples output pin pad", 64'(rd), 64'h01);
    settle();
    check("R7 input pin level from pad", 64'(pin_level[0]), 64'h1);
    check("R7 output pin level from register", 64'(pin_level[48]), 64'h0);
    do_write(8'h26, 8'h01, 8'h01);
    settle();
    check("R7 output pin level follows register", 64'(pin_level[48]), 64'h1);
    do_write(8'h40, 8'h00, 8'hFF);
    do_read(8'h40, rd); check("R5 write to input ignored", 64'(rd), 64'h01);

    // R12 read data holds without a strobe
    do_read(8'h50, rd); check("R12 read alt", 64'(rd), 64'h96);
    @(negedge clk); host_addr = 8'h00;
    @(negedge clk);
    check("R12 rdata holds while re low", 64'(host_rdata), 64'h96);

    // R1 reset after activity
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1 pin_oe cleared by reset", 64'(pin_oe), 64'h0);
    check("R1 pin_pd_en cleared by reset", 64'(pin_pd_en), 64'h0);
    do_read(8'h48, rd); check("R1 fields none after reset", 64'(rd), 64'h55);
    do_read(8'h00, rd); check("R1 select cleared", 64'(rd), 64'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule